// File: doc/BRIEF.md
# Mode-Dependent Timer Value Readback

This block is one channel of a general-purpose timer. It holds a 16-bit low counter, an 8-bit prescaler that extends it to a 24-bit count, and a second 16-bit half that can be chained above the low counter for a 32-bit count. It also holds an input edge detector and a timestamp capture register. A single 32-bit read-only value word is assembled from this state, and what it means depends on the selected mode. In the counting modes it is the live counter. In edge-count mode it is the number of qualified input edges. In edge-time mode it is the count captured at the most recent qualified edge.

Software loads all counters at once from a 32-bit load word. The `run_i` input advances the counters in the live modes. The edge input passes through a two-flop synchronizer and is qualified by a polarity selection. When the alternate clock source is flagged, the live-count readback is reduced by one. The value word is purely combinational over the state, so a read never disturbs the timer.

Top module: `tmr_value_rb`

## Requirements
- R1: After reset the low counter, the prescaler, the upper half and the capture register are all ones. The value word then reads 0xFFFFFFFF in concatenated mode and 0x00FFFFFF in edge-time mode.
- R2: The mode encodings on `mode_i` are 0 periodic-16, 1 edge-count, 2 edge-time, 3 pwm-16 and 4 concatenated-32. A `load_i` pulse loads bits 15:0 of `load_val_i` into the low counter, bits 23:16 into the prescaler and bits 31:16 into the upper half, one clock later. In every mode except edge-count, each clock with `run_i` high decrements the low counter by one, wrapping from 0 to 0xFFFF.
- R3: In periodic-16 mode, and for the unused codes 5 to 7, the value word is the low counter in bits 15:0 with bits 31:16 zero.
- R4: In pwm-16 mode the value word is {8'h00, prescaler, low counter}. The prescaler decrements when the low counter wraps from 0, and bits 31:24 read zero whatever was loaded.
- R5: In concatenated-32 mode the value word is {upper half, low counter}. The upper half decrements when the low counter wraps from 0, and the prescaler is frozen.
- R6: In edge-count mode the 24-bit {prescaler, low counter} count rises by one per qualified edge, carrying from the low counter into the prescaler. `run_i` has no effect. The value word is {8'h00, prescaler, low counter}.
- R7: On `pol_i`, 0 qualifies no edge, 1 qualifies rising edges, 2 qualifies falling edges and 3 qualifies both. A change on `edge_in_i` takes effect on the third rising clock edge after it.
- R8: In edge-time mode each qualified edge captures the current {prescaler, low counter} value. The capture holds between edges, and the value word is {8'h00, capture}.
- R9: With `alt_clk_i` high, the value word in the periodic-16, pwm-16 and concatenated-32 modes is the live count minus one, wrapping within that mode's width. The edge modes are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Operating mode |
| pol_i | input | 2 | Edge polarity selection |
| alt_clk_i | input | 1 | Alternate clock source selected |
| run_i | input | 1 | Count enable for live modes |
| load_i | input | 1 | Load all counters from load_val_i |
| load_val_i | input | 32 | Load word |
| edge_in_i | input | 1 | Asynchronous event input |
| value_o | output | 32 | Mode-dependent value word |

## Verification
Each mode is loaded with a distinct known pattern and then run or pulsed for a counted number of cycles. A wrap of the low counter tells the prescaler chaining in pwm-16 apart from the upper-half chaining in concatenated-32. A load with a nonzero top byte shows that the 16-bit modes clear bits 31:24. In edge-count mode the input is toggled under each of the four polarity settings, which separates rising, falling, both and none, and a start just below 0x10000 exposes the carry into the prescaler. In edge-time mode the counter is frozen at known values, so that a capture, a hold across a load and an unqualified edge each give a distinct readback. The alternate-clock flag is toggled in three live modes and in one edge mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    MODE_PER16 = 3'd0,
    MODE_ECNT  = 3'd1,
    MODE_ETIME = 3'd2,
    MODE_PWM16 = 3'd3,
    MODE_CAT32 = 3'd4
  } tmr_mode_e;

  typedef enum logic [1:0] {
    POL_NONE = 2'd0,
    POL_RISE = 2'd1,
    POL_FALL = 2'd2,
    POL_BOTH = 2'd3
  } edge_pol_e;
endpackage

// File: rtl/tmr_cnt.sv
module tmr_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         up_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '1;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (en_i)  cnt_q <= up_i ? cnt_q + W'(1) : cnt_q - W'(1);
  end

  assign cnt_o = cnt_q;

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> cnt_q == $past(ld_val_i));
  p_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ld_i && !up_i) |=> cnt_q == $past(cnt_q) - W'(1));
endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
  parameter int SYNC_N = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_i,
  input  logic [1:0] pol_i,
  output logic       edge_o
);
  // sh[SYNC_N-1] is the synchronized level, sh[SYNC_N] its previous value
  logic [SYNC_N:0] sh_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_N-1:0], in_i};
  end

  assign rise   = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
  assign fall   = ~sh_q[SYNC_N-1] & sh_q[SYNC_N];
  assign edge_o = (rise & pol_i[0]) | (fall & pol_i[1]);

  p_no_edge_none_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_i == 2'd0) |-> !edge_o);
endmodule

// File: rtl/tmr_value_rb.sv
module tmr_value_rb
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2:0]           mode_i,
  input  logic [1:0]           pol_i,
  input  logic                 alt_clk_i,
  input  logic                 run_i,
  input  logic                 load_i,
  input  logic [2*CNT_W-1:0]   load_val_i,
  input  logic                 edge_in_i,
  output logic [2*CNT_W-1:0]   value_o
);
  localparam int VAL_W = 2 * CNT_W;
  localparam int TS_W  = CNT_W + PRE_W;
  localparam int PAD_W = VAL_W - TS_W;

  logic [CNT_W-1:0] lo_cnt, hi_cnt;
  logic [PRE_W-1:0] pre_cnt;
  logic [TS_W-1:0]  cap_q, ts;
  logic is_ecnt, is_etime, is_pwm, is_cat;
  logic edge_q, lo_en, lo_term, pre_en, hi_en;
  logic [CNT_W-1:0] sub16;
  logic [TS_W-1:0]  sub24;
  logic [VAL_W-1:0] sub32;

  assign is_ecnt  = (mode_i == MODE_ECNT);
  assign is_etime = (mode_i == MODE_ETIME);
  assign is_pwm   = (mode_i == MODE_PWM16);
  assign is_cat   = (mode_i == MODE_CAT32);

  tmr_edge_det #(.SYNC_N(2)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(edge_in_i), .pol_i(pol_i), .edge_o(edge_q)
  );

  assign lo_en   = is_ecnt ? edge_q : run_i;
  assign lo_term = is_ecnt ? (&lo_cnt) : ~|lo_cnt;
  assign pre_en  = lo_en & lo_term & ~is_cat;
  assign hi_en   = lo_en & lo_term & is_cat;

  tmr_cnt #(.W(CNT_W)) u_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(lo_en), .up_i(is_ecnt), .ld_i(load_i),
    .ld_val_i(load_val_i[CNT_W-1:0]), .cnt_o(lo_cnt)
  );
  tmr_cnt #(.W(PRE_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(pre_en), .up_i(is_ecnt), .ld_i(load_i),
    .ld_val_i(load_val_i[TS_W-1:CNT_W]), .cnt_o(pre_cnt)
  );
  tmr_cnt #(.W(CNT_W)) u_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(hi_en), .up_i(1'b0), .ld_i(load_i),
    .ld_val_i(load_val_i[VAL_W-1:CNT_W]), .cnt_o(hi_cnt)
  );

  assign ts = {pre_cnt, lo_cnt};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cap_q <= '1;
    else if (is_etime && edge_q) cap_q <= ts;
  end

  // alternate clock source: live count reads one lower
  assign sub16 = lo_cnt - CNT_W'(alt_clk_i);
  assign sub24 = ts - TS_W'(alt_clk_i);
  assign sub32 = {hi_cnt, lo_cnt} - VAL_W'(alt_clk_i);

  always_comb begin
    case (mode_i)
      MODE_ECNT:  value_o = {{PAD_W{1'b0}}, ts};
      MODE_ETIME: value_o = {{PAD_W{1'b0}}, cap_q};
      MODE_PWM16: value_o = {{PAD_W{1'b0}}, sub24};
      MODE_CAT32: value_o = sub32;
      default:    value_o = {{CNT_W{1'b0}}, sub16};
    endcase
  end

  p_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_etime && edge_q) |=> cap_q == $past(ts));
  p_cap_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(is_etime && edge_q) |=> $stable(cap_q));
  p_ecnt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ecnt && edge_q && !load_i) |=> ts == $past(ts) + TS_W'(1));
  p_ecnt_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ecnt && !edge_q && !load_i) |=> $stable(ts));
  p_cat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cat && run_i && lo_cnt == '0 && !load_i) |=> hi_cnt == $past(hi_cnt) - CNT_W'(1));
  p_top_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pwm || is_ecnt || is_etime) |-> value_o[VAL_W-1:TS_W] == '0);
endmodule

// File: tb/sim_tmr_value_rb.sv
module sim_tmr_value_rb;
  import tmr_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  mode_i = 3'd4;
  logic [1:0]  pol_i = 2'd0;
  logic        alt_clk_i = 1'b0;
  logic        run_i = 1'b0;
  logic        load_i = 1'b0;
  logic [31:0] load_val_i = '0;
  logic        edge_in_i = 1'b0;
  logic [31:0] value_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  tmr_value_rb u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .pol_i(pol_i),
    .alt_clk_i(alt_clk_i), .run_i(run_i), .load_i(load_i),
    .load_val_i(load_val_i), .edge_in_i(edge_in_i), .value_o(value_o)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [31:0] v);
    load_val_i = v; load_i = 1'b1;
    cyc(1);
    load_i = 1'b0;
  endtask

  task automatic set_edge(input logic lvl);
    edge_in_i = lvl;
    cyc(3);
  endtask

  task automatic t_reset;
    #1 chk("R1 reset cat32", value_o, 32'hFFFF_FFFF);
    mode_i = MODE_ETIME;
    #1 chk("R1 reset capture", value_o, 32'h00FF_FFFF);
  endtask

  task automatic t_per16;
    mode_i = MODE_PER16;
    do_load(32'h0012_3456);
    chk("R2 load per16", value_o, 32'h0000_3456);
    run_i = 1'b1; cyc(5); run_i = 1'b0;
    chk("R2 down count", value_o, 32'h0000_3451);
    mode_i = 3'd6;
    #1 chk("R3 unused code", value_o, 32'h0000_3451);
    mode_i = MODE_PER16;
    alt_clk_i = 1'b1;
    #1 chk("R9 alt per16", value_o, 32'h0000_3450);
    alt_clk_i = 1'b0;
  endtask

  task automatic t_pwm;
    mode_i = MODE_PWM16;
    do_load(32'hAB01_0002);
    chk("R4 top byte zero", value_o, 32'h0001_0002);
    run_i = 1'b1; cyc(3); run_i = 1'b0;
    chk("R4 prescaler borrow", value_o, 32'h0000_FFFF);
    alt_clk_i = 1'b1;
    #1 chk("R9 alt pwm16", value_o, 32'h0000_FFFE);
    alt_clk_i = 1'b0;
  endtask

  task automatic t_cat;
    mode_i = MODE_CAT32;
    do_load(32'h0002_0000);
    run_i = 1'b1; cyc(1); run_i = 1'b0;
    chk("R5 upper borrow", value_o, 32'h0001_FFFF);
    alt_clk_i = 1'b1;
    #1 chk("R9 alt cat32", value_o, 32'h0001_FFFE);
    alt_clk_i = 1'b0;
    do_load(32'h0000_0000);
    run_i = 1'b1; cyc(1); run_i = 1'b0;
    chk("R5 full wrap", value_o, 32'hFFFF_FFFF);
  endtask

  task automatic t_ecnt;
    mode_i = MODE_ECNT; pol_i = POL_RISE;
    do_load(32'h0000_FFFE);
    run_i = 1'b1;
    set_edge(1'b1);
    chk("R6 first edge", value_o, 32'h0000_FFFF);
    set_edge(1'b0);
    chk("R7 fall ignored on rise pol", value_o, 32'h0000_FFFF);
    set_edge(1'b1);
    chk("R6 carry into prescaler", value_o, 32'h0001_0000);
    alt_clk_i = 1'b1;
    #1 chk("R9 alt no effect ecnt", value_o, 32'h0001_0000);
    alt_clk_i = 1'b0;
    set_edge(1'b0);
    run_i = 1'b0;
    pol_i = POL_FALL;
    set_edge(1'b1);
    chk("R7 rise ignored on fall pol", value_o, 32'h0001_0000);
    set_edge(1'b0);
    chk("R7 fall counted", value_o, 32'h0001_0001);
    pol_i = POL_BOTH;
    set_edge(1'b1);
    chk("R7 both rise", value_o, 32'h0001_0002);
    set_edge(1'b0);
    chk("R7 both fall", value_o, 32'h0001_0003);
    pol_i = POL_NONE;
    set_edge(1'b1);
    set_edge(1'b0);
    chk("R7 none", value_o, 32'h0001_0003);
  endtask

  task automatic t_etime;
    mode_i = MODE_ETIME; pol_i = POL_RISE;
    do_load(32'h0000_0300);
    chk("R8 capture before edge", value_o, 32'h00FF_FFFF);
    edge_in_i = 1'b1;
    cyc(2);
    chk("R7 latency not yet", value_o, 32'h00FF_FFFF);
    cyc(1);
    chk("R8 captured", value_o, 32'h0000_0300);
    do_load(32'h0000_0500);
    chk("R8 hold across load", value_o, 32'h0000_0300);
    set_edge(1'b0);
    chk("R8 unqualified edge", value_o, 32'h0000_0300);
    set_edge(1'b1);
    chk("R8 recapture", value_o, 32'h0000_0500);
  endtask

  initial begin
    cyc(2);
    rst_ni = 1'b1;
    cyc(1);
    t_reset();
    t_per16();
    t_pwm();
    t_cat();
    t_ecnt();
    t_etime();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule